// File: doc/BRIEF.md
# Edge-Triggered Indirect Register Bridge

This block lets a host reach a 16-bit internal control-register port through a pair of 64-bit registers. The host writes a command register that carries four command bits and a 16-bit operand field. It reads a status register that returns an acknowledge flag and the most recent read result. Rising edges on the command bits do the work. Two commands latch the operand as the target address or as the write value. The other two start a read or a write transfer on the internal port.

Every command finishes with a four-phase handshake:
1. Software raises one command bit.
2. Software waits for the acknowledge flag to go high.
3. Software writes zero to the command register.
4. Software waits for the acknowledge flag to go low before it issues the next command.

A full internal write therefore takes three handshakes: capture address, capture data, then write. A read takes two: capture address, then read.

The internal port is a simple request/done interface. The block holds a read or write request, together with the latched address and data, until the port returns a one-cycle done pulse. On a read, the port delivers its data with that pulse.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the status register reads all zero (acknowledge clear, read result zero), the latched address and write value are zero, and no internal request is active.
- R2: A rising edge on command bit 3 latches command bits 47:32 as the internal address (seen on ip_addr). The acknowledge flag (status bit 0) rises on the second clock edge after the host write, with no internal request issued.
- R3: A rising edge on command bit 2 latches command bits 47:32 as the write value (seen on ip_wdata). The acknowledge flag rises on the second clock edge after the host write.
- R4: A rising edge on command bit 1 raises ip_rd with the latched address. The request holds until ip_done. The acknowledge flag stays low until the edge after ip_done and then rises, and status bits 47:32 then hold the ip_rdata value sampled with ip_done.
- R5: A rising edge on command bit 0 raises ip_wr with the latched address and write value, held until ip_done. The acknowledge flag rises on the edge after ip_done.
- R6: Once raised, the acknowledge flag stays high while any of command bits 3:0 is set. It falls on the first clock edge at which the command register holds all four bits at zero.
- R7: When several command bits rise in one host write, only the highest-priority one is acted on, in the order bit 3, bit 2, bit 1, bit 0. The others are dropped.
- R8: Rising edges that arrive while a transfer is pending or while the acknowledge flag is high are dropped. They change neither the latched address nor the latched data, and they start no request.
- R9: Status bits 63:48 and 31:1 always read zero.
- R10: ip_rd and ip_wr are never high together, and a request never starts while the acknowledge flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host write strobe for the command register |
| cfg_wdata | input | 64 | Host write value: bits 3:0 commands, bits 47:32 operand |
| stat_rdata | output | 64 | Status: bit 0 acknowledge, bits 47:32 last read result |
| ip_addr | output | 16 | Internal port address (latched) |
| ip_wdata | output | 16 | Internal port write value (latched) |
| ip_rd | output | 1 | Internal read request, held until done |
| ip_wr | output | 1 | Internal write request, held until done |
| ip_rdata | input | 16 | Internal port read data, valid with ip_done |
| ip_done | input | 1 | One-cycle completion pulse from the internal port |

## Verification
The main path runs a table of address/value pairs through full write sequences and then read-back sequences. The pairs include all-ones, all-zero, single-bit and mixed patterns, with distinct addresses, so a swapped or stale address or operand shows up as a wrong memory entry or a wrong status field. A read of a location that was never written returns its initial contents and so confirms the read path on its own. Commands are also issued with several bits rising at once, to separate the four priority levels. New edges are issued while the acknowledge flag is held high, which separates dropping them from queueing them. Cycle-exact samples of the acknowledge flag around capture and release tell a one-cycle response apart from an early or late one.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  localparam int NCMD     = 4;
  localparam int CMD_WR   = 0;
  localparam int CMD_RD   = 1;
  localparam int CMD_CAPD = 2;
  localparam int CMD_CAPA = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_ACKED = 2'd2
  } ibr_state_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WR   = 3'd1,
    OP_RD   = 3'd2,
    OP_CAPD = 3'd3,
    OP_CAPA = 3'd4
  } ibr_op_e;

endpackage

// File: rtl/ibr_edge.sv
module ibr_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/ibr_pick.sv
module ibr_pick
  import ibr_pkg::*;
(
  input  logic [NCMD-1:0] rise,
  output ibr_op_e         op
);

  always_comb begin
    if (rise[CMD_CAPA])      op = OP_CAPA;
    else if (rise[CMD_CAPD]) op = OP_CAPD;
    else if (rise[CMD_RD])   op = OP_RD;
    else if (rise[CMD_WR])   op = OP_WR;
    else                     op = OP_NONE;
  end

endmodule

// File: rtl/ibr_ctrl.sv
module ibr_ctrl
  import ibr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ibr_op_e       op,
  input  logic          any_cmd,
  input  logic [DW-1:0] din,
  input  logic          ip_done,
  input  logic [DW-1:0] ip_rdata,
  output logic [DW-1:0] ip_addr,
  output logic [DW-1:0] ip_wdata,
  output logic          ip_rd,
  output logic          ip_wr,
  output logic          ack,
  output logic [DW-1:0] dout
);

  ibr_state_e    st_q, st_d;
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          rd_q, rd_d;
  logic          wr_q, wr_d;
  logic          ack_q, ack_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    dout_d = dout_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    ack_d  = ack_q;
    case (st_q)
      ST_IDLE: begin
        case (op)
          OP_CAPA: begin
            addr_d = din;
            ack_d  = 1'b1;
            st_d   = ST_ACKED;
          end
          OP_CAPD: begin
            wdat_d = din;
            ack_d  = 1'b1;
            st_d   = ST_ACKED;
          end
          OP_RD: begin
            rd_d = 1'b1;
            st_d = ST_BUSY;
          end
          OP_WR: begin
            wr_d = 1'b1;
            st_d = ST_BUSY;
          end
          default: ;
        endcase
      end
      ST_BUSY: begin
        if (ip_done) begin
          if (rd_q) dout_d = ip_rdata;
          rd_d  = 1'b0;
          wr_d  = 1'b0;
          ack_d = 1'b1;
          st_d  = ST_ACKED;
        end
      end
      ST_ACKED: begin
        if (!any_cmd) begin
          ack_d = 1'b0;
          st_d  = ST_IDLE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        rd_d  = 1'b0;
        wr_d  = 1'b0;
        ack_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
      dout_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      dout_q <= dout_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      ack_q  <= ack_d;
    end
  end

  assign ip_addr  = addr_q;
  assign ip_wdata = wdat_q;
  assign ip_rd    = rd_q;
  assign ip_wr    = wr_q;
  assign ack      = ack_q;
  assign dout     = dout_q;

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int REG_W     = 64,
  parameter int DW        = 16,
  parameter int FIELD_LSB = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] stat_rdata,
  output logic [DW-1:0]    ip_addr,
  output logic [DW-1:0]    ip_wdata,
  output logic             ip_rd,
  output logic             ip_wr,
  input  logic [DW-1:0]    ip_rdata,
  input  logic             ip_done
);

  localparam int FIELD_MSB = FIELD_LSB + DW - 1;

  logic [REG_W-1:0] cfg_q;
  logic [NCMD-1:0]  cmd_rise;
  ibr_op_e          op;
  logic             ack_w;
  logic [DW-1:0]    dout_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  ibr_edge #(.W(NCMD)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (cfg_q[NCMD-1:0]),
    .rise (cmd_rise)
  );

  ibr_pick u_pick (
    .rise(cmd_rise),
    .op  (op)
  );

  ibr_ctrl #(.DW(DW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .any_cmd (|cfg_q[NCMD-1:0]),
    .din     (cfg_q[FIELD_MSB:FIELD_LSB]),
    .ip_done (ip_done),
    .ip_rdata(ip_rdata),
    .ip_addr (ip_addr),
    .ip_wdata(ip_wdata),
    .ip_rd   (ip_rd),
    .ip_wr   (ip_wr),
    .ack     (ack_w),
    .dout    (dout_w)
  );

  always_comb begin
    stat_rdata                       = '0;
    stat_rdata[0]                    = ack_w;
    stat_rdata[FIELD_MSB:FIELD_LSB]  = dout_w;
  end

endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    cmd_lvl,
  input logic          ack,
  input logic          ip_rd,
  input logic          ip_wr,
  input logic          ip_done,
  input logic [DW-1:0] ip_addr,
  input logic [DW-1:0] ip_wdata,
  input logic [DW-1:0] ip_rdata,
  input logic [DW-1:0] dout
);

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (cmd_lvl != 4'd0)) |=> ack) else $error("ack dropped early"); // R6

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (cmd_lvl == 4'd0)) |=> !ack) else $error("ack stuck"); // R6

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ip_rd && ip_wr)) else $error("rd and wr together"); // R10

  AST_QUIET_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !(ip_rd || ip_wr)) else $error("request during ack"); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_rd && !ip_done) |=> (ip_rd && $stable(ip_addr))) else $error("read request unstable"); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_wr && !ip_done) |=> (ip_wr && $stable(ip_addr) && $stable(ip_wdata))) else $error("write request unstable"); // R5

  AST_DONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ip_rd || ip_wr) && ip_done) |=> (ack && !ip_rd && !ip_wr)) else $error("no ack after done"); // R4

  AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_rd && ip_done) |=> (dout == $past(ip_rdata))) else $error("read data not captured"); // R4

  AST_NO_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_rd || ip_wr) |-> !ack) else $error("ack while pending"); // R5

endmodule

bind ind_reg_bridge ibr_checker #(.DW(DW)) u_ibr_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_lvl (cfg_q[3:0]),
  .ack     (ack_w),
  .ip_rd   (ip_rd),
  .ip_wr   (ip_wr),
  .ip_done (ip_done),
  .ip_addr (ip_addr),
  .ip_wdata(ip_wdata),
  .ip_rdata(ip_rdata),
  .dout    (dout_w)
);

// File: tb/test_ind_reg_bridge.sv
`timescale 1ns/1ps
module test_ind_reg_bridge;

  localparam int NV = 6;
  // {address, value}
  localparam logic [31:0] VEC [NV] = '{
    32'h0005_BEEF, 32'h00AC_0001, 32'h7FF1_FFFF,
    32'h8002_8000, 32'hFFFF_5A5A, 32'h0000_0000
  };
  localparam logic [3:0] C_WR = 4'b0001, C_RD = 4'b0010,
                         C_CD = 4'b0100, C_CA = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [63:0] cfg_wdata;
  logic [63:0] stat_rdata;
  logic [15:0] ip_addr, ip_wdata, ip_rdata;
  logic        ip_rd, ip_wr, ip_done;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int both_cnt = 0;
  logic req_seen;
  int lat;
  logic [15:0] mem [16];
  logic [15:0] last_wa, last_wd;

  always #4 clk = ~clk;

  ind_reg_bridge i_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stat_rdata(stat_rdata), .ip_addr(ip_addr), .ip_wdata(ip_wdata),
    .ip_rd(ip_rd), .ip_wr(ip_wr), .ip_rdata(ip_rdata), .ip_done(ip_done)
  );

  // Internal port model: done three cycles after a request appears
  always @(negedge clk) begin
    if (!rst_n) begin
      ip_done  <= 1'b0;
      ip_rdata <= '0;
      lat      <= 0;
      req_seen <= 1'b0;
      last_wa  <= '0;
      last_wd  <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i);
    end else begin
      if ((ip_rd || ip_wr) && !req_seen) req_cnt <= req_cnt + 1;
      if (ip_rd && ip_wr) both_cnt <= both_cnt + 1;
      req_seen <= ip_rd || ip_wr;
      if (ip_done) begin
        ip_done <= 1'b0;
        lat     <= 0;
      end else if (ip_rd || ip_wr) begin
        if (lat == 3) begin
          ip_done <= 1'b1;
          if (ip_rd) ip_rdata <= mem[ip_addr[3:0]];
          if (ip_wr) begin
            mem[ip_addr[3:0]] <= ip_wdata;
            last_wa <= ip_addr;
            last_wd <= ip_wdata;
          end
        end else lat <= lat + 1;
      end else lat <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] cmd, input logic [15:0] din);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {16'h0, din, 28'h0, cmd};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_ack(input logic lvl, input string tag);
    int n = 0;
    while (stat_rdata[0] !== lvl && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) chk(1'b0, tag, {63'h0, stat_rdata[0]}, {63'h0, lvl});
  endtask

  task automatic do_cmd(input logic [3:0] cmd, input logic [15:0] din, input string tag);
    host_wr(cmd, din);
    wait_ack(1'b1, tag);
    host_wr(4'h0, 16'h0);
    wait_ack(1'b0, tag);
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(stat_rdata == 64'h0, "R1 status", stat_rdata, 64'h0);
    chk(ip_addr == 0 && ip_wdata == 0, "R1 latches", {ip_addr, ip_wdata}, 64'h0);
    chk(!ip_rd && !ip_wr, "R1 request", {ip_rd, ip_wr}, 64'h0);

    // R2 capture address timing
    host_wr(C_CA, 16'h0009);
    chk(stat_rdata[0] == 1'b0, "R2 ack one cycle late", stat_rdata[0], 0);
    @(negedge clk);
    chk(stat_rdata[0] == 1'b1, "R2 ack rise", stat_rdata[0], 1);
    chk(ip_addr == 16'h0009, "R2 address", ip_addr, 16'h0009);
    // R6 ack holds while bit set, drops one edge after clear
    repeat (4) @(negedge clk);
    chk(stat_rdata[0] == 1'b1, "R6 hold", stat_rdata[0], 1);
    host_wr(4'h0, 16'h0);
    chk(stat_rdata[0] == 1'b1, "R6 not yet low", stat_rdata[0], 1);
    @(negedge clk);
    chk(stat_rdata[0] == 1'b0, "R6 low", stat_rdata[0], 0);

    // R4 read of untouched location, ack waits for done
    rc = req_cnt;
    host_wr(C_RD, 16'h0);
    @(negedge clk);
    chk(ip_rd && stat_rdata[0] == 1'b0, "R4 pending no ack", {ip_rd, stat_rdata[0]}, 2'b10);
    wait_ack(1'b1, "R4 ack");
    chk(stat_rdata[47:32] == 16'h1009, "R4 data", stat_rdata[47:32], 16'h1009);
    chk(req_cnt == rc + 1, "R4 one request", req_cnt, rc + 1);
    host_wr(4'h0, 16'h0);
    wait_ack(1'b0, "R4 release");

    // Main table: write then read back (R2 R3 R5 R4)
    for (int i = 0; i < NV; i++) begin
      do_cmd(C_CA, VEC[i][31:16], "R2 cap");
      do_cmd(C_CD, VEC[i][15:0], "R3 cap");
      chk(ip_wdata == VEC[i][15:0], "R3 value", ip_wdata, VEC[i][15:0]);
      do_cmd(C_WR, 16'h0, "R5 wr");
      chk(last_wa == VEC[i][31:16] && last_wd == VEC[i][15:0], "R5 write",
          {last_wa, last_wd}, VEC[i]);
    end
    for (int i = 0; i < NV; i++) begin
      do_cmd(C_CA, VEC[i][31:16], "R2 cap");
      host_wr(C_RD, 16'h0);
      wait_ack(1'b1, "R4 rd");
      chk(stat_rdata[47:32] == VEC[i][15:0], "R4 readback", stat_rdata[47:32], VEC[i][15:0]);
      chk((stat_rdata & ~64'h0000_FFFF_0000_0001) == 64'h0, "R9 zero bits", stat_rdata, 64'h0);
      host_wr(4'h0, 16'h0);
      wait_ack(1'b0, "R4 rd rel");
    end

    // R7 priority
    do_cmd(C_CD, 16'h1111, "R7 setup");
    rc = req_cnt;
    do_cmd(4'b1111, 16'h2222, "R7 all");
    chk(ip_addr == 16'h2222 && ip_wdata == 16'h1111, "R7 addr wins",
        {ip_addr, ip_wdata}, {16'h2222, 16'h1111});
    do_cmd(4'b0111, 16'h3333, "R7 three");
    chk(ip_addr == 16'h2222 && ip_wdata == 16'h3333, "R7 data wins",
        {ip_addr, ip_wdata}, {16'h2222, 16'h3333});
    chk(req_cnt == rc, "R7 no request", req_cnt, rc);
    do_cmd(4'b0011, 16'h0, "R7 rd over wr");
    chk(last_wa != 16'h2222, "R7 read not write", last_wa, 16'h0);
    chk(req_cnt == rc + 1, "R7 one request", req_cnt, rc + 1);

    // R8 edges during ack are dropped
    rc = req_cnt;
    host_wr(C_CD, 16'h4444);
    wait_ack(1'b1, "R8 ack");
    host_wr(4'b1111, 16'h5555);
    repeat (6) @(negedge clk);
    chk(stat_rdata[0] == 1'b1, "R8 ack held", stat_rdata[0], 1);
    host_wr(4'h0, 16'h0);
    wait_ack(1'b0, "R8 rel");
    chk(ip_addr == 16'h2222 && ip_wdata == 16'h4444, "R8 latches unchanged",
        {ip_addr, ip_wdata}, {16'h2222, 16'h4444});
    chk(req_cnt == rc, "R8 no request", req_cnt, rc);

    // R10 exclusivity over the whole run
    chk(both_cnt == 0, "R10 exclusive", both_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule